// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame is kept, based on its identifier. Two programmable filter lists are held inside it. One list serves 11-bit standard identifiers and holds up to 128 elements. The other serves 29-bit extended identifiers and holds up to 64 elements. Each element is set up as one of three kinds: an inclusive identifier range, an identifier compared under a bit mask, or an exact identifier.

The receive path presents an identifier and its type flag together with a one-cycle start strobe. The block then walks the active elements of the selected list in ascending index order, one element per clock. It stops at the first element that matches. At the end it pulses `done` and gives an accept or reject verdict, together with the index of the element that matched. A frame that is rejected must not be stored by the downstream logic.

Elements and list sizes are loaded through a simple write-only register port. Each list has its own count of active elements.

Top module: `can_id_filter`

## Requirements
- R1: Reset state. After reset, `busy`, `done`, `accept` and `hit_idx` are 0. Both active counts are 0, and every stored element is disabled.
- R2: Timing. A `start` sampled while idle latches `id_in` and `id_ext` and raises `busy` at that edge. Element j is examined in the clock cycle that follows edge j of the scan. When element j matches, `done` is high after the (j+1)-th edge following the start edge, and `busy` falls at that same edge.
- R3: Range kind (`cfg_kind` = 0). The element matches when `cfg_id1` <= id <= `cfg_id2`, both bounds included.
- R4: Mask kind (`cfg_kind` = 1). `cfg_id2` acts as the mask. The element matches when (id AND mask) equals (`cfg_id1` AND mask).
- R5: Exact kind (`cfg_kind` = 2). The element matches only when id equals `cfg_id1`. Kind 3 never matches.
- R6: Priority. When several elements match, the one with the lowest index wins and its index is reported.
- R7: Disabled elements. An element written with `cfg_en` = 0 never matches, but it still takes one scan cycle.
- R8: No match. When no active element matches, `done` pulses with `accept` = 0 and `hit_idx` = 0 after one cycle per active element. An empty list gives its verdict after one cycle.
- R9: List selection. `id_ext` = 0 searches the standard list and compares only `id_in[10:0]`. `id_ext` = 1 searches the extended list and compares all 29 bits.
- R10: Active count. `cfg_cnt_we` writes `cfg_cnt` as the active count of list `cfg_list` (0 = standard, 1 = extended). A value larger than the list depth is clamped to the depth. Elements at or beyond the active count never match.
- R11: A `start` that arrives while a scan is running is ignored. The running scan keeps its identifier and its timing.
- R12: `done` lasts exactly one cycle. `accept` and `hit_idx` keep their values until the next `done`.
- R13: Element writes. `cfg_we` writes the element at `cfg_idx` into list `cfg_list`. A write to an index at or beyond that list's depth is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan of the presented identifier |
| id_in | input | 29 | Received identifier; standard frames use bits 10:0 |
| id_ext | input | 1 | 1 = extended identifier, 0 = standard identifier |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| accept | output | 1 | Verdict: 1 = frame passes the filter |
| hit_idx | output | 7 | Index of the matching element (0 on reject) |
| cfg_we | input | 1 | Write one filter element |
| cfg_list | input | 1 | Target list for writes: 0 = standard, 1 = extended |
| cfg_idx | input | 7 | Element index to write |
| cfg_kind | input | 2 | Element kind: 0 range, 1 mask, 2 exact, 3 none |
| cfg_en | input | 1 | Element enable |
| cfg_id1 | input | 29 | Lower bound, reference identifier, or exact identifier |
| cfg_id2 | input | 29 | Upper bound or mask |
| cfg_cnt_we | input | 1 | Write the active element count of `cfg_list` |
| cfg_cnt | input | 8 | Active element count (clamped to the list depth) |

## Verification
The bench builds lists in which an early wide range shadows a later exact element. A design that scans in the wrong order, or that keeps the last match rather than the first, reports the wrong index for such an identifier. A disabled duplicate sits in front of an enabled one, and an enabled element sits just past the active count. An off-by-one end test would therefore either accept a frame it should reject, or finish a cycle early or late. The latency of every scan is measured in edges. The bench also presents a standard identifier with the upper 18 bits set, sends a start in the middle of a scan, writes an extended element out of range (which a truncating write would alias onto element 0), and sets a count above the depth. Each of these exposes a distinct corruption of the verdict or its timing.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  localparam int XID_W = 29;
  localparam int SID_W = 11;

  typedef enum logic [1:0] {
    FK_RANGE = 2'd0,
    FK_MASK  = 2'd1,
    FK_EXACT = 2'd2,
    FK_NONE  = 2'd3
  } fkind_e;

  typedef struct packed {
    logic              en;
    fkind_e            kind;
    logic [XID_W-1:0]  a;   // low bound / reference / exact id
    logic [XID_W-1:0]  b;   // high bound / mask
  } felem_t;

  // Does element e accept identifier id?
  function automatic logic elem_hit(input felem_t e, input logic [XID_W-1:0] id);
    logic r;
    r = 1'b0;
    if (e.en) begin
      unique case (e.kind)
        FK_RANGE: r = (id >= e.a) && (id <= e.b);
        FK_MASK:  r = ((id ^ e.a) & e.b) == '0;
        FK_EXACT: r = (id == e.a);
        default:  r = 1'b0;
      endcase
    end
    return r;
  endfunction

  // Reduce an identifier to the width its list compares.
  function automatic logic [XID_W-1:0] id_view(input logic [XID_W-1:0] id, input logic ext);
    return ext ? id : {{(XID_W-SID_W){1'b0}}, id[SID_W-1:0]};
  endfunction

endpackage

// File: rtl/cfilt_list.sv
module cfilt_list
  import can_filt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int IDW   = 11,
  parameter int IXW   = 7,
  localparam int CW   = IXW + 1,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [IXW-1:0] widx,
  input  felem_t         wdat,
  input  logic           cnt_we,
  input  logic [CW-1:0]  cnt_in,
  input  logic [IXW-1:0] ridx,
  output felem_t         rdat,
  output logic [CW-1:0]  cnt_q
);

  logic           en_q   [DEPTH];
  fkind_e         kind_q [DEPTH];
  logic [IDW-1:0] a_q    [DEPTH];
  logic [IDW-1:0] b_q    [DEPTH];

  logic w_ok, r_ok;
  logic [AW-1:0] wa, ra;

  assign w_ok = ({1'b0, widx} < CW'(DEPTH));
  assign r_ok = ({1'b0, ridx} < CW'(DEPTH));
  assign wa   = widx[AW-1:0];
  assign ra   = ridx[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        en_q[i]   <= 1'b0;
        kind_q[i] <= FK_NONE;
        a_q[i]    <= '0;
        b_q[i]    <= '0;
      end
    end else if (we && w_ok) begin
      en_q[wa]   <= wdat.en;
      kind_q[wa] <= wdat.kind;
      a_q[wa]    <= wdat.a[IDW-1:0];
      b_q[wa]    <= wdat.b[IDW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= (cnt_in > CW'(DEPTH)) ? CW'(DEPTH) : cnt_in;
  end

  always_comb begin
    rdat = '0;
    rdat.kind = FK_NONE;
    if (r_ok) begin
      rdat.en   = en_q[ra];
      rdat.kind = kind_q[ra];
      rdat.a    = XID_W'(a_q[ra]);
      rdat.b    = XID_W'(b_q[ra]);
    end
  end

endmodule

// File: rtl/cfilt_scan.sv
module cfilt_scan
  import can_filt_pkg::*;
#(
  parameter int IXW = 7,
  localparam int CW = IXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XID_W-1:0] id_in,
  input  logic             id_ext,
  input  logic             step_hit,
  input  logic [CW-1:0]    act_cnt,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IXW-1:0]   hit_idx,
  output logic [IXW-1:0]   scan_idx,
  output logic             scan_ext,
  output logic [XID_W-1:0] scan_id
);

  logic in_list, at_last, take;

  assign in_list = ({1'b0, scan_idx} < act_cnt);
  assign at_last = (CW'(scan_idx) + CW'(1)) >= act_cnt;
  assign take    = in_list && step_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      accept   <= 1'b0;
      hit_idx  <= '0;
      scan_idx <= '0;
      scan_ext <= 1'b0;
      scan_id  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          scan_idx <= '0;
          scan_ext <= id_ext;
          scan_id  <= id_view(id_in, id_ext);
        end
      end else if (take) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        accept  <= 1'b1;
        hit_idx <= scan_idx;
      end else if (at_last) begin
        busy    <= 1'b0;
        done    <= 1'b1;
        accept  <= 1'b0;
        hit_idx <= '0;
      end else begin
        scan_idx <= scan_idx + IXW'(1);
      end
    end
  end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
  import can_filt_pkg::*;
#(
  parameter int STD_DEPTH = 128,
  parameter int EXT_DEPTH = 64,
  localparam int MAXD = (STD_DEPTH > EXT_DEPTH) ? STD_DEPTH : EXT_DEPTH,
  localparam int IXW  = $clog2(MAXD),
  localparam int CW   = IXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XID_W-1:0] id_in,
  input  logic             id_ext,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IXW-1:0]   hit_idx,
  input  logic             cfg_we,
  input  logic             cfg_list,
  input  logic [IXW-1:0]   cfg_idx,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_en,
  input  logic [XID_W-1:0] cfg_id1,
  input  logic [XID_W-1:0] cfg_id2,
  input  logic             cfg_cnt_we,
  input  logic [CW-1:0]    cfg_cnt
);

  felem_t           wdat;
  felem_t           std_elem, ext_elem, cur_elem;
  logic [CW-1:0]    std_cnt, ext_cnt, act_cnt;
  logic [IXW-1:0]   scan_idx;
  logic             scan_ext;
  logic [XID_W-1:0] scan_id;
  logic             step_hit;

  assign wdat.en   = cfg_en;
  assign wdat.kind = fkind_e'(cfg_kind);
  assign wdat.a    = cfg_id1;
  assign wdat.b    = cfg_id2;

  cfilt_list #(.DEPTH(STD_DEPTH), .IDW(SID_W), .IXW(IXW)) u_std (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we && !cfg_list), .widx(cfg_idx), .wdat(wdat),
    .cnt_we(cfg_cnt_we && !cfg_list), .cnt_in(cfg_cnt),
    .ridx(scan_idx), .rdat(std_elem), .cnt_q(std_cnt)
  );

  cfilt_list #(.DEPTH(EXT_DEPTH), .IDW(XID_W), .IXW(IXW)) u_ext (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we && cfg_list), .widx(cfg_idx), .wdat(wdat),
    .cnt_we(cfg_cnt_we && cfg_list), .cnt_in(cfg_cnt),
    .ridx(scan_idx), .rdat(ext_elem), .cnt_q(ext_cnt)
  );

  assign cur_elem = scan_ext ? ext_elem : std_elem;
  assign act_cnt  = scan_ext ? ext_cnt  : std_cnt;
  assign step_hit = elem_hit(cur_elem, scan_id);

  cfilt_scan #(.IXW(IXW)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .start(start), .id_in(id_in), .id_ext(id_ext),
    .step_hit(step_hit), .act_cnt(act_cnt),
    .busy(busy), .done(done), .accept(accept), .hit_idx(hit_idx),
    .scan_idx(scan_idx), .scan_ext(scan_ext), .scan_id(scan_id)
  );

endmodule

// File: rtl/can_id_filter_chk.sv
module can_id_filter_chk #(
  parameter int IXW = 7,
  localparam int CW = IXW + 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           accept,
  input logic [IXW-1:0] hit_idx,
  input logic [IXW-1:0] scan_idx,
  input logic [CW-1:0]  act_cnt
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2

  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R2

  AST_DONE_AFTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R2

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && scan_idx == '0)); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (scan_idx == $past(scan_idx) + IXW'(1))); // R11

  AST_HIT_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept) |-> ({1'b0, hit_idx} < $past(act_cnt))); // R10

  AST_REJECT_ZERO_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |-> (hit_idx == '0)); // R8

endmodule

bind can_id_filter can_id_filter_chk #(.IXW(IXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .accept(accept), .hit_idx(hit_idx), .scan_idx(scan_idx), .act_cnt(act_cnt)
);

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [28:0] id_in = '0;
  logic        id_ext = 1'b0;
  logic        busy, done, accept;
  logic [6:0]  hit_idx;
  logic        cfg_we = 1'b0, cfg_list = 1'b0, cfg_en = 1'b0, cfg_cnt_we = 1'b0;
  logic [6:0]  cfg_idx = '0;
  logic [1:0]  cfg_kind = '0;
  logic [28:0] cfg_id1 = '0, cfg_id2 = '0;
  logic [7:0]  cfg_cnt = '0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  can_id_filter u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .id_in(id_in), .id_ext(id_ext),
    .busy(busy), .done(done), .accept(accept), .hit_idx(hit_idx),
    .cfg_we(cfg_we), .cfg_list(cfg_list), .cfg_idx(cfg_idx), .cfg_kind(cfg_kind),
    .cfg_en(cfg_en), .cfg_id1(cfg_id1), .cfg_id2(cfg_id2),
    .cfg_cnt_we(cfg_cnt_we), .cfg_cnt(cfg_cnt)
  );

  // {ext, id[28:0], accept, idx[6:0], latency[7:0]}
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 29'h150,      1'b1, 7'd0, 8'd1},  // R3 inside range
    {1'b0, 29'h100,      1'b1, 7'd0, 8'd1},  // R3 low bound
    {1'b0, 29'h1FF,      1'b1, 7'd0, 8'd1},  // R3 high bound
    {1'b0, 29'h0FF,      1'b0, 7'd0, 8'd6},  // R3 below range, R8
    {1'b0, 29'h200,      1'b0, 7'd0, 8'd6},  // R3 above range, R8
    {1'b0, 29'h2A5,      1'b1, 7'd1, 8'd2},  // R4 mask hit
    {1'b0, 29'h2B5,      1'b0, 7'd0, 8'd6},  // R4 masked bit differs
    {1'b0, 29'h123,      1'b1, 7'd0, 8'd1},  // R6 range shadows exact idx2
    {1'b0, 29'h555,      1'b1, 7'd4, 8'd5},  // R7 disabled idx3 skipped
    {1'b0, 29'h600,      1'b0, 7'd0, 8'd6},  // R5 kind 3 never matches
    {1'b0, 29'h700,      1'b0, 7'd0, 8'd6},  // R10 idx6 beyond count
    {1'b0, 29'h1FFFF950, 1'b1, 7'd0, 8'd1},  // R9 upper bits ignored
    {1'b1, 29'h1ABCDEF0, 1'b1, 7'd0, 8'd1},  // R5 R9 extended exact
    {1'b1, 29'h1ABCDEF1, 1'b0, 7'd0, 8'd3},  // R5 off by one rejected
    {1'b1, 29'h00150000, 1'b1, 7'd1, 8'd2},  // R3 extended range
    {1'b1, 29'h18123456, 1'b1, 7'd2, 8'd3}   // R4 extended mask
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_elem(input logic lst, input int idx, input int kind, input logic en,
                         input logic [28:0] a, input logic [28:0] b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_list = lst; cfg_idx = 7'(idx); cfg_kind = 2'(kind);
    cfg_en = en; cfg_id1 = a; cfg_id2 = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic lst, input int n);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_list = lst; cfg_cnt = 8'(n);
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  // Starts a scan and counts edges after the start edge until done is seen.
  task automatic scan(input logic ext, input logic [28:0] id,
                      output logic acc, output logic [6:0] idx, output int lat);
    @(negedge clk);
    start = 1'b1; id_in = id; id_ext = ext;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (!done && lat < 300);
    acc = accept; idx = hit_idx;
  endtask

  initial begin
    logic       acc;
    logic [6:0] idx;
    int         lat;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 accept", 32'(accept), 0);
    chk("R1 hit_idx", 32'(hit_idx), 0);
    rst_n = 1'b1;

    // R1 R8: empty standard list rejects after one cycle
    scan(1'b0, 29'h150, acc, idx, lat);
    chk("R1 empty list accept", 32'(acc), 0);
    chk("R8 empty list latency", 32'(lat), 1);

    // Standard list: kinds 0 range, 1 mask (id2 = mask), 2 exact, 3 none
    wr_elem(1'b0, 0, 0, 1'b1, 29'h100, 29'h1FF);
    wr_elem(1'b0, 1, 1, 1'b1, 29'h2A0, 29'h7F0);
    wr_elem(1'b0, 2, 2, 1'b1, 29'h123, 29'h0);
    wr_elem(1'b0, 3, 2, 1'b0, 29'h555, 29'h0);
    wr_elem(1'b0, 4, 2, 1'b1, 29'h555, 29'h0);
    wr_elem(1'b0, 5, 3, 1'b1, 29'h600, 29'h7FF);
    wr_elem(1'b0, 6, 2, 1'b1, 29'h700, 29'h0);
    wr_cnt(1'b0, 6);
    // Extended list
    wr_elem(1'b1, 0, 2, 1'b1, 29'h1ABCDEF0, 29'h0);
    wr_elem(1'b1, 1, 0, 1'b1, 29'h00100000, 29'h001FFFFF);
    wr_elem(1'b1, 2, 1, 1'b1, 29'h18000000, 29'h1F000000);
    wr_elem(1'b1, 64, 2, 1'b1, 29'h000ABCDE, 29'h0); // R13 out of range, dropped
    wr_cnt(1'b1, 3);

    for (int v = 0; v < NV; v++) begin
      scan(VEC[v][45], VEC[v][44:16], acc, idx, lat);
      chk($sformatf("R2 vec%0d accept", v), 32'(acc), 32'(VEC[v][15]));
      chk($sformatf("R6 vec%0d hit_idx", v), 32'(idx), 32'(VEC[v][14:8]));
      chk($sformatf("R2 vec%0d latency", v), 32'(lat), 32'(VEC[v][7:0]));
    end

    // R13 write beyond extended depth must not alias element 0
    scan(1'b1, 29'h000ABCDE, acc, idx, lat);
    chk("R13 dropped write accept", 32'(acc), 0);
    chk("R13 dropped write latency", 32'(lat), 3);

    // R12 done is one cycle; verdict holds
    scan(1'b0, 29'h555, acc, idx, lat);
    @(negedge clk);
    chk("R12 done low next cycle", 32'(done), 0);
    repeat (3) @(negedge clk);
    chk("R12 accept holds", 32'(accept), 1);
    chk("R12 hit_idx holds", 32'(hit_idx), 4);

    // R11 start while busy ignored
    @(negedge clk);
    start = 1'b1; id_in = 29'h0FF; id_ext = 1'b0;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    @(posedge clk); @(negedge clk);
    start = 1'b1; id_in = 29'h150;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 300) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    chk("R11 running scan kept id", 32'(accept), 0);
    chk("R11 running scan latency", 32'(lat), 6);
    @(negedge clk);
    chk("R11 no second verdict", 32'(busy | done), 0);

    // R10 count clamps to depth
    wr_cnt(1'b0, 200);
    scan(1'b0, 29'h700, acc, idx, lat);
    chk("R10 clamped count accept", 32'(acc), 1);
    chk("R10 clamped count idx", 32'(idx), 6);
    chk("R10 clamped count latency", 32'(lat), 7);
    scan(1'b0, 29'h7FF, acc, idx, lat);
    chk("R10 full list reject", 32'(acc), 0);
    chk("R10 full list latency", 32'(lat), 128);

    // R8 extended empty list
    wr_cnt(1'b1, 0);
    scan(1'b1, 29'h1ABCDEF0, acc, idx, lat);
    chk("R8 empty ext accept", 32'(acc), 0);
    chk("R8 empty ext latency", 32'(lat), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule